// File: doc/BRIEF.md
# Polled Byte Input Port

This block receives bytes from an external device that runs outside the local clock domain and makes them available to a processor through a small read port. The device drives a byte and raises a valid strobe. A two-flop synchroniser brings the strobe into the clock domain. On the synchronised rising edge, the port stores the byte, raises an accept line back to the device, and sets a ready flag that the processor can see.

The processor polls the status register until the ready flag is set. It then reads the data register, and that read clears the flag. The accept line falls only after two things have happened: the device has dropped its valid strobe, and the processor has consumed the byte. This completes a four-phase handshake and prevents the next byte from arriving before the processor is ready for it.

The controller has two states:
- `S_IDLE` means the accept line is low and the port is waiting for a byte.
- `S_ACK` means the accept line is high.

There are two transitions:
- `CAPTURE` moves `S_IDLE` to `S_ACK` on a valid rising edge while the ready flag is clear.
- `RELEASE` moves `S_ACK` to `S_IDLE` once the synchronised valid is low and the ready flag is clear.

If a valid rising edge arrives while the ready flag is still set, the port records an overrun and keeps the stored byte unchanged.

Top module: `byte_rx_port`

## Requirements
- R1: After reset, dev_accept is low, the status register reads 0 and the data register reads 0; a reset in mid-transfer clears all of them again.
- R2: A byte on dev_data is stored on the third rising clock edge after dev_valid goes high (two synchroniser stages plus one edge-detect stage), and the data register then returns it.
- R3: The edge that stores a byte also sets status bit 0 (ready) and raises dev_accept (state S_IDLE to S_ACK).
- R4: A read with rd_en high and rd_addr = 1 (data register) clears status bit 0 and status bit 1 on the next clock edge.
- R5: dev_accept stays high while dev_valid is still high, even after the byte has been read, and it also stays high after dev_valid falls until the byte is read.
- R6: dev_accept falls on the first edge at which the synchronised valid is low and the ready flag is already clear; this is the third edge after dev_valid falls when the read came first.
- R7: A synchronised valid rising edge while ready is set sets status bit 1 (overrun), leaves the stored byte unchanged, and keeps bit 1 set until a data-register read.
- R8: A read with rd_en high and rd_addr = 0 (status register) leaves both status bits unchanged.
- R9: rd_data is combinational on rd_addr. With rd_addr = 0 it returns {6'b0, overrun, ready}, and with rd_addr = 1 it returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_data | input | 8 | Byte from the device, held stable while dev_valid is high |
| dev_valid | input | 1 | Device strobe, asynchronous to clk |
| dev_accept | output | 1 | Accept line back to the device |
| rd_en | input | 1 | Processor read strobe; a data read clears the flags |
| rd_addr | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Read data, combinational on rd_addr |

## Verification
The overrun case is the hardest to reach, because a device that obeys the handshake never causes it. The accept line must still be high when a fresh valid edge arrives. To get there, the bench plays a faulty device: it drops valid while the byte is still unread, waits until the low level has passed through the synchroniser, and then raises valid again with a different byte. It then checks that both flags are set and that the first byte is still in the data register. It also drives both orders of the release phase (read before valid drops, and valid drops before read) and checks the exact edge at which accept falls in each case.

// File: rtl/byte_rx_pkg.sv
package byte_rx_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } hs_state_t;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_DATA   = 1'b1;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_OVR_BIT   = 1;
endpackage

// File: rtl/byte_rx_sync.sv
module byte_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/byte_rx_ctrl.sv
module byte_rx_ctrl
    import byte_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_s,
    input  logic ready,
    output logic capture,
    output logic ovr_hit,
    output logic accept
);
    hs_state_t state_q, state_d;
    logic      valid_q;
    logic      valid_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_s;
    end

    assign valid_rise = valid_s & ~valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (capture) state_d = S_ACK;
            S_ACK:  if (!valid_s && !ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture = valid_rise & ~ready;
        ovr_hit = valid_rise & ready;
        accept  = (state_q == S_ACK);
    end
endmodule

// File: rtl/byte_rx_regs.sv
module byte_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              ovr_hit,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              ovr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (capture) data_q <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ready_q <= 1'b0;
        else if (capture) ready_q <= 1'b1;
        else if (data_rd) ready_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_hit) ovr_q <= 1'b1;
        else if (data_rd) ovr_q <= 1'b0;
    end
endmodule

// File: rtl/byte_rx_port.sv
module byte_rx_port
    import byte_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_valid,
    output logic              dev_accept,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - 2;

    logic              valid_s;
    logic              capture;
    logic              ovr_hit;
    logic              data_rd;
    logic [DATA_W-1:0] data_q;
    logic              ready_q;
    logic              ovr_q;
    logic [DATA_W-1:0] status_word;

    byte_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_valid),
        .sync_out (valid_s)
    );

    byte_rx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_s (valid_s),
        .ready   (ready_q),
        .capture (capture),
        .ovr_hit (ovr_hit),
        .accept  (dev_accept)
    );

    assign data_rd = rd_en && (rd_addr == ADDR_DATA);

    byte_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .ovr_hit (ovr_hit),
        .data_rd (data_rd),
        .din     (dev_data),
        .data_q  (data_q),
        .ready_q (ready_q),
        .ovr_q   (ovr_q)
    );

    always_comb begin
        status_word = {{PAD_W{1'b0}}, 2'b00};
        status_word[STAT_READY_BIT] = ready_q;
        status_word[STAT_OVR_BIT]   = ovr_q;
    end

    assign rd_data = (rd_addr == ADDR_DATA) ? data_q : status_word;
endmodule

// File: rtl/byte_rx_port_chk.sv
module byte_rx_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_accept,
    input logic              rd_en,
    input logic              rd_addr,
    input logic              ready,
    input logic              overrun,
    input logic [DATA_W-1:0] data_q
);
    p_accept_with_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_accept) |-> ready);

    p_ready_raises_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> dev_accept);

    p_data_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_en && rd_addr) |=> (!ready && !overrun));

    p_status_read_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(rd_en && rd_addr)) |=> ready);

    p_accept_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_accept) |-> !ready);

    p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(data_q));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(rd_en && rd_addr)) |=> overrun);
endmodule

bind byte_rx_port byte_rx_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_accept (dev_accept),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .ready      (ready_q),
    .overrun    (ovr_q),
    .data_q     (data_q)
);

// File: tb/byte_rx_port_tb.sv
module byte_rx_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {order, byte}: order 0 = drop valid then read, 1 = read then drop valid
    localparam logic [8:0] VEC [NVEC] = '{
        9'h000, 9'h1FF, 9'h0A5, 9'h15A, 9'h001, 9'h180, 9'h03C, 9'h1C3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dev_data = 8'h00;
    logic       dev_valid = 1'b0;
    logic       dev_accept;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    byte_rx_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_data   (dev_data),
        .dev_valid  (dev_valid),
        .dev_accept (dev_accept),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic addr, output logic [7:0] val);
        rd_addr = addr;
        #1;
        val = rd_data;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle data read, issued at a negedge
    task automatic read_data();
        rd_en = 1'b1;
        rd_addr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // raise valid with a byte and wait for the capture edge
    task automatic send(input logic [7:0] b, input string tag);
        dev_data = b;
        dev_valid = 1'b1;
        wait_neg(2);
        chk({tag, " R2 accept before capture"}, {7'b0, dev_accept}, 8'h00);
        wait_neg(1);
    endtask

    initial begin
        logic [7:0] v;
        wait_neg(2);
        // R1: reset state
        peek(1'b0, v); chk("R1 status after reset", v, 8'h00);
        peek(1'b1, v); chk("R1 data after reset", v, 8'h00);
        chk("R1 accept after reset", {7'b0, dev_accept}, 8'h00);
        rst_n = 1'b1;
        wait_neg(2);

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][7:0], "vec");
            chk("R3 accept at capture", {7'b0, dev_accept}, 8'h01);
            peek(1'b0, v); chk("R3 R9 status ready", v, 8'h01);
            peek(1'b1, v); chk("R2 R9 data byte", v, VEC[i][7:0]);
            if (VEC[i][8] == 1'b0) begin
                dev_valid = 1'b0;
                wait_neg(4);
                chk("R5 accept held until read", {7'b0, dev_accept}, 8'h01);
                read_data();
                peek(1'b0, v); chk("R4 status cleared", v, 8'h00);
                chk("R6 accept before release edge", {7'b0, dev_accept}, 8'h01);
                wait_neg(1);
                chk("R6 accept released", {7'b0, dev_accept}, 8'h00);
            end else begin
                read_data();
                peek(1'b0, v); chk("R4 status cleared", v, 8'h00);
                wait_neg(3);
                chk("R5 accept held while valid", {7'b0, dev_accept}, 8'h01);
                dev_valid = 1'b0;
                wait_neg(2);
                chk("R6 accept two edges after drop", {7'b0, dev_accept}, 8'h01);
                wait_neg(1);
                chk("R6 accept three edges after drop", {7'b0, dev_accept}, 8'h00);
            end
            wait_neg(2);
        end

        // R8: status reads do not clear the flag
        send(8'h77, "r8");
        rd_en = 1'b1; rd_addr = 1'b0;
        wait_neg(3);
        rd_en = 1'b0;
        peek(1'b0, v); chk("R8 status read keeps ready", v, 8'h01);
        chk("R8 accept kept", {7'b0, dev_accept}, 8'h01);

        // R7: protocol violation gives overrun
        dev_valid = 1'b0;
        wait_neg(3);
        dev_data = 8'h99;
        dev_valid = 1'b1;
        wait_neg(3);
        peek(1'b0, v); chk("R7 overrun and ready", v, 8'h03);
        peek(1'b1, v); chk("R7 byte kept", v, 8'h77);
        rd_en = 1'b1; rd_addr = 1'b0;
        wait_neg(2);
        rd_en = 1'b0;
        peek(1'b0, v); chk("R7 overrun sticky", v, 8'h03);
        dev_valid = 1'b0;
        wait_neg(3);
        read_data();
        peek(1'b0, v); chk("R4 overrun cleared by data read", v, 8'h00);
        wait_neg(1);
        chk("R6 accept released after overrun", {7'b0, dev_accept}, 8'h00);

        // R1: reset mid-transfer
        send(8'h42, "r1");
        rst_n = 1'b0;
        #1;
        peek(1'b0, v); chk("R1 status after mid reset", v, 8'h00);
        peek(1'b1, v); chk("R1 data after mid reset", v, 8'h00);
        chk("R1 accept after mid reset", {7'b0, dev_accept}, 8'h00);
        dev_valid = 1'b0;
        wait_neg(2);
        rst_n = 1'b1;
        wait_neg(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule